// File: doc/BRIEF.md
# PLL Divider Programming Interface

This block holds the configuration for the dividers of an integer-N synthesizer: a prescaler enable, a 9-bit main count M, a 4-bit swallow count A and a 6-bit reference count R. It keeps these in a 20-bit staging word (primary) and a 20-bit active word (secondary), plus an 8-bit word of extra control bits (enhancement). A pair of mode pins picks one of three ways to program it, and all three share the same input pins. In serial mode a clocked bit stream is shifted in. In parallel mode an 8-bit bus is loaded field by field with separate write strobes. In direct mode the counts are wired straight from pins.

Every pin is sampled in the single system clock domain. Strobes, and the serial clock, act on the rising edge that this sampling detects. A transfer strobe copies the staging word into the active word, so a complete new setting can be prepared and then switched in at once. A select pin decides whether the dividers see the staging word or the active word. The control bits only reach their output while an active-low enable pin is held low.

A three-state mode machine follows the mode pins on every clock. Its states are MODE_PARALLEL (the reset state), MODE_SERIAL and MODE_DIRECT. Its transitions are TO_DIRECT (from either other state, when bus_mode is high), TO_SERIAL (from parallel or direct, when bus_mode is low and ser_mode is high) and TO_PARALLEL (from serial or direct, when both are low). Otherwise the machine holds its state.

Top module: `pll_prog_if`

## Requirements
- R1: Mode selection: bus_mode=1 selects direct mode. bus_mode=0 with ser_mode=1 selects serial mode. bus_mode=0 with ser_mode=0 selects parallel mode. Parallel strobes have no effect in serial mode.
- R2: In serial mode, each rising sclk with s_wr low and e_wr low shifts sdata into bit 0 of the staging word, and the older bits move one place up (MSB first). The word layout is bit 19 prescaler enable, bits 18:10 M, bits 9:4 R and bits 3:0 A.
- R3: In serial mode, each rising sclk with e_wr high shifts sdata MSB first into the 8-bit control word. The staging word stays unchanged.
- R4: A rising s_wr in serial mode, or a rising hop_wr in serial or parallel mode, copies the staging word into the active word.
- R5: In parallel mode, a rising m1_wr loads dbus[7] into the prescaler enable and dbus[6:0] into M[6:0].
- R6: In parallel mode, a rising m2_wr loads dbus[3:2] into R[5:4] and dbus[1:0] into M[8:7].
- R7: In parallel mode, a rising a_wr loads dbus[7:4] into R[3:0] and dbus[3:0] into A[3:0].
- R8: In parallel mode, a rising e_wr loads dbus[7:0] into the control word.
- R9: Outside direct mode, use_primary=1 drives the divider outputs from the staging word, and use_primary=0 drives them from the active word.
- R10: enh_bits shows the control word while enh_n is low, and is zero while enh_n is high.
- R11: In direct mode, cfg_pre_en=dbus[7], cfg_m={2'b00,dbus[6:0]}, cfg_a=dir_a and cfg_r={2'b00,dir_r}. Strobes and the serial clock leave all three stored words unchanged.
- R12: After reset all stored words are zero, the block is in parallel mode and every output is zero.
- R13: A change on a mode, select, enable or direct-value pin reaches the outputs one clock after the edge that samples it. A register write reaches the outputs one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | High selects direct mode |
| ser_mode | input | 1 | With bus_mode low: high selects serial mode, low selects parallel mode |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, MSB first |
| s_wr | input | 1 | Serial staging-word enable (low) and transfer strobe (rising) |
| e_wr | input | 1 | Serial control-word enable (high); parallel control-word strobe |
| m1_wr | input | 1 | Parallel strobe for prescaler enable and M[6:0] |
| m2_wr | input | 1 | Parallel strobe for R[5:4] and M[8:7] |
| a_wr | input | 1 | Parallel strobe for R[3:0] and A |
| hop_wr | input | 1 | Transfer strobe, staging word to active word |
| dbus | input | 8 | Parallel data; prescaler enable and M[6:0] in direct mode |
| dir_a | input | 4 | Direct-mode A value |
| dir_r | input | 4 | Direct-mode R[3:0] value |
| use_primary | input | 1 | 1 selects the staging word, 0 the active word |
| enh_n | input | 1 | Active-low enable for the control-word output |
| cfg_pre_en | output | 1 | Prescaler enable to the dividers |
| cfg_m | output | 9 | M count |
| cfg_r | output | 6 | R count |
| cfg_a | output | 4 | A count |
| enh_bits | output | 8 | Gated control word |

## Verification
All pins are sampled on the same rising edge. A mode, select, enable or direct-value change is therefore due on the outputs one clock after that edge, and a strobe or sclk write is due two clocks after it. The bench drives pins only on falling edges and reads outputs only on falling edges. A model steps once per rising edge and works from the pins it saw on the two previous edges, and its prediction is compared with the outputs at every falling edge. Directed checks count out these one-edge and two-edge delays explicitly, reading the old value after one rising edge and the new value after the second.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;

    localparam int DBUS_W  = 8;
    localparam int M_W     = 9;
    localparam int A_W     = 4;
    localparam int R_W     = 6;
    localparam int ENH_W   = 8;
    localparam int DIR_R_W = 4;
    localparam int PRI_W   = 1 + M_W + R_W + A_W;

    // bit positions inside the 20-bit word: {pre_en, M, R, A}
    localparam int A_LSB   = 0;
    localparam int R_LSB   = A_LSB + A_W;
    localparam int M_LSB   = R_LSB + R_W;
    localparam int PRE_BIT = PRI_W - 1;

    // parallel field split
    localparam int M_LO_W  = DBUS_W - 1;
    localparam int M_HI_W  = M_W - M_LO_W;
    localparam int R_LO_W  = DBUS_W - A_W;
    localparam int R_HI_W  = R_W - R_LO_W;

    // strobe vector indices
    localparam int STB_SCLK = 0;
    localparam int STB_SWR  = 1;
    localparam int STB_EWR  = 2;
    localparam int STB_M1   = 3;
    localparam int STB_M2   = 4;
    localparam int STB_AWR  = 5;
    localparam int STB_HOP  = 6;
    localparam int NUM_STB  = 7;

    typedef enum logic [1:0] {
        MODE_PARALLEL = 2'd0,
        MODE_SERIAL   = 2'd1,
        MODE_DIRECT   = 2'd2
    } mode_e;

    typedef struct packed {
        logic             pre_en;
        logic [M_W-1:0]   m;
        logic [R_W-1:0]   r;
        logic [A_W-1:0]   a;
    } word_t;

endpackage

// File: rtl/pll_prog_sampler.sv
module pll_prog_sampler #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] rise
);

    logic [W-1:0] cur_q;
    logic [W-1:0] old_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q[i] <= 1'b0;
                old_q[i] <= 1'b0;
            end else begin
                cur_q[i] <= pins[i];
                old_q[i] <= cur_q[i];
            end
        end
        assign rise[i] = cur_q[i] & ~old_q[i];
    end

endmodule

// File: rtl/pll_prog_mode_fsm.sv
module pll_prog_mode_fsm
    import pll_prog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_mode,
    input  logic ser_mode,
    output logic ser_active,
    output logic par_active,
    output logic dir_active
);

    mode_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_PARALLEL: begin
                if (bus_mode)      state_nx = MODE_DIRECT;
                else if (ser_mode) state_nx = MODE_SERIAL;
            end
            MODE_SERIAL: begin
                if (bus_mode)       state_nx = MODE_DIRECT;
                else if (!ser_mode) state_nx = MODE_PARALLEL;
            end
            MODE_DIRECT: begin
                if (!bus_mode) state_nx = ser_mode ? MODE_SERIAL : MODE_PARALLEL;
            end
            default: state_nx = MODE_PARALLEL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_PARALLEL;
        else        state <= state_nx;
    end

    always_comb begin
        ser_active = 1'b0;
        par_active = 1'b0;
        dir_active = 1'b0;
        unique case (state)
            MODE_PARALLEL: par_active = 1'b1;
            MODE_SERIAL:   ser_active = 1'b1;
            MODE_DIRECT:   dir_active = 1'b1;
            default:       par_active = 1'b1;
        endcase
    end

    // R1
    direct_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode |=> dir_active && !ser_active && !par_active);

    // R1
    serial_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mode && ser_mode) |=> ser_active && !dir_active);

    // R1
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ser_active, par_active, dir_active}) == 1);

endmodule

// File: rtl/pll_prog_regs.sv
module pll_prog_regs
    import pll_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_active,
    input  logic               par_active,
    input  logic [NUM_STB-1:0] rise,
    input  logic               s_wr_lvl,
    input  logic               e_wr_lvl,
    input  logic               sdata_q,
    input  logic [DBUS_W-1:0]  d_q,
    output logic [PRI_W-1:0]   pri_r,
    output logic [PRI_W-1:0]   sec_r,
    output logic [ENH_W-1:0]   enh_r
);

    logic [PRI_W-1:0] pri_nx;
    logic [PRI_W-1:0] sec_nx;
    logic [ENH_W-1:0] enh_nx;
    logic             xfer;

    assign xfer = (ser_active && rise[STB_SWR]) ||
                  ((ser_active || par_active) && rise[STB_HOP]);

    always_comb begin
        pri_nx = pri_r;
        sec_nx = sec_r;
        enh_nx = enh_r;

        if (ser_active && rise[STB_SCLK]) begin
            if (e_wr_lvl)
                enh_nx = {enh_r[ENH_W-2:0], sdata_q};
            else if (!s_wr_lvl)
                pri_nx = {pri_r[PRI_W-2:0], sdata_q};
        end

        if (xfer)
            sec_nx = pri_r;

        if (par_active) begin
            if (rise[STB_M1]) begin
                pri_nx[PRE_BIT]          = d_q[DBUS_W-1];
                pri_nx[M_LSB +: M_LO_W]  = d_q[M_LO_W-1:0];
            end
            if (rise[STB_M2]) begin
                pri_nx[M_LSB + M_LO_W +: M_HI_W] = d_q[M_HI_W-1:0];
                pri_nx[R_LSB + R_LO_W +: R_HI_W] = d_q[M_HI_W +: R_HI_W];
            end
            if (rise[STB_AWR]) begin
                pri_nx[R_LSB +: R_LO_W] = d_q[A_W +: R_LO_W];
                pri_nx[A_LSB +: A_W]    = d_q[A_W-1:0];
            end
            if (rise[STB_EWR])
                enh_nx = d_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_r <= '0;
            sec_r <= '0;
            enh_r <= '0;
        end else begin
            pri_r <= pri_nx;
            sec_r <= sec_nx;
            enh_r <= enh_nx;
        end
    end

    // R2
    ser_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_active && rise[STB_SCLK] && !e_wr_lvl && !s_wr_lvl)
        |=> (pri_r[0] == $past(sdata_q)) && (pri_r[PRI_W-1:1] == $past(pri_r[PRI_W-2:0])));

    // R3
    enh_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_active && rise[STB_SCLK] && e_wr_lvl)
        |=> (enh_r[0] == $past(sdata_q)) && $stable(pri_r));

    // R4
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ser_active && rise[STB_SWR]) || (par_active && rise[STB_HOP]))
        |=> sec_r == $past(pri_r));

    // R8
    par_enh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_active && rise[STB_EWR]) |=> enh_r == $past(d_q));

    // R11
    direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_active && !par_active) |=> $stable(pri_r) && $stable(sec_r) && $stable(enh_r));

endmodule

// File: rtl/pll_prog_if.sv
module pll_prog_if
    import pll_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_mode,
    input  logic               ser_mode,
    input  logic               sclk,
    input  logic               sdata,
    input  logic               s_wr,
    input  logic               e_wr,
    input  logic               m1_wr,
    input  logic               m2_wr,
    input  logic               a_wr,
    input  logic               hop_wr,
    input  logic [DBUS_W-1:0]  dbus,
    input  logic [A_W-1:0]     dir_a,
    input  logic [DIR_R_W-1:0] dir_r,
    input  logic               use_primary,
    input  logic               enh_n,
    output logic               cfg_pre_en,
    output logic [M_W-1:0]     cfg_m,
    output logic [R_W-1:0]     cfg_r,
    output logic [A_W-1:0]     cfg_a,
    output logic [ENH_W-1:0]   enh_bits
);

    logic [NUM_STB-1:0] stb_pins;
    logic [NUM_STB-1:0] stb_rise;
    logic               ser_active, par_active, dir_active;
    logic [PRI_W-1:0]   pri_r, sec_r;
    logic [ENH_W-1:0]   enh_r;

    logic [DBUS_W-1:0]  dbus_q;
    logic [A_W-1:0]     dir_a_q;
    logic [DIR_R_W-1:0] dir_r_q;
    logic               sdata_q, s_wr_q, e_wr_q, sel_q, enh_n_q;
    word_t              chosen;

    assign stb_pins[STB_SCLK] = sclk;
    assign stb_pins[STB_SWR]  = s_wr;
    assign stb_pins[STB_EWR]  = e_wr;
    assign stb_pins[STB_M1]   = m1_wr;
    assign stb_pins[STB_M2]   = m2_wr;
    assign stb_pins[STB_AWR]  = a_wr;
    assign stb_pins[STB_HOP]  = hop_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbus_q  <= '0;
            dir_a_q <= '0;
            dir_r_q <= '0;
            sdata_q <= 1'b0;
            s_wr_q  <= 1'b0;
            e_wr_q  <= 1'b0;
            sel_q   <= 1'b0;
            enh_n_q <= 1'b0;
        end else begin
            dbus_q  <= dbus;
            dir_a_q <= dir_a;
            dir_r_q <= dir_r;
            sdata_q <= sdata;
            s_wr_q  <= s_wr;
            e_wr_q  <= e_wr;
            sel_q   <= use_primary;
            enh_n_q <= enh_n;
        end
    end

    pll_prog_sampler #(.W(NUM_STB)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (stb_pins),
        .rise  (stb_rise)
    );

    pll_prog_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_mode   (bus_mode),
        .ser_mode   (ser_mode),
        .ser_active (ser_active),
        .par_active (par_active),
        .dir_active (dir_active)
    );

    pll_prog_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_active (ser_active),
        .par_active (par_active),
        .rise       (stb_rise),
        .s_wr_lvl   (s_wr_q),
        .e_wr_lvl   (e_wr_q),
        .sdata_q    (sdata_q),
        .d_q        (dbus_q),
        .pri_r      (pri_r),
        .sec_r      (sec_r),
        .enh_r      (enh_r)
    );

    always_comb begin
        chosen = sel_q ? word_t'(pri_r) : word_t'(sec_r);
        if (dir_active) begin
            cfg_pre_en = dbus_q[DBUS_W-1];
            cfg_m      = {{M_HI_W{1'b0}}, dbus_q[M_LO_W-1:0]};
            cfg_a      = dir_a_q;
            cfg_r      = {{(R_W-DIR_R_W){1'b0}}, dir_r_q};
        end else begin
            cfg_pre_en = chosen.pre_en;
            cfg_m      = chosen.m;
            cfg_a      = chosen.a;
            cfg_r      = chosen.r;
        end
        enh_bits = enh_n_q ? '0 : enh_r;
    end

    // R10
    enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enh_n) |-> enh_bits == '0);

    // R11
    direct_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_mode) |-> (cfg_m[M_W-1:M_LO_W] == '0) && (cfg_r[R_W-1:DIR_R_W] == '0));

endmodule

// File: tb/tb_pll_prog_if.sv
module tb_pll_prog_if;
    import pll_prog_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_mode = 0, ser_mode = 0, sclk = 0, sdata = 0, s_wr = 0, e_wr = 0;
    logic m1_wr = 0, m2_wr = 0, a_wr = 0, hop_wr = 0, use_primary = 0, enh_n = 0;
    logic [7:0] dbus = '0;
    logic [3:0] dir_a = '0, dir_r = '0;
    logic       cfg_pre_en;
    logic [8:0] cfg_m;
    logic [5:0] cfg_r;
    logic [3:0] cfg_a;
    logic [7:0] enh_bits;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    pll_prog_if dut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .ser_mode(ser_mode),
        .sclk(sclk), .sdata(sdata), .s_wr(s_wr), .e_wr(e_wr), .m1_wr(m1_wr),
        .m2_wr(m2_wr), .a_wr(a_wr), .hop_wr(hop_wr), .dbus(dbus), .dir_a(dir_a),
        .dir_r(dir_r), .use_primary(use_primary), .enh_n(enh_n),
        .cfg_pre_en(cfg_pre_en), .cfg_m(cfg_m), .cfg_r(cfg_r), .cfg_a(cfg_a),
        .enh_bits(enh_bits)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [6:0]  p1_stb, p0_stb;   // {hop,a,m2,m1,e,s,sclk}
    logic [7:0]  p1_d;
    logic        p1_sd, p1_bm, p1_sm, p1_sel, p1_en;
    logic [3:0]  p1_da, p1_dr;
    logic [19:0] mdl_pri, mdl_sec;
    logic [7:0]  mdl_enh;

    always @(posedge clk or negedge rst_n) begin : mdl
        logic [6:0]  up;
        logic [19:0] np;
        bit          ser, par;
        if (!rst_n) begin
            p1_stb = '0; p0_stb = '0; p1_d = '0; p1_sd = 0; p1_bm = 0; p1_sm = 0;
            p1_sel = 0; p1_en = 0; p1_da = '0; p1_dr = '0;
            mdl_pri = '0; mdl_sec = '0; mdl_enh = '0;
        end else begin
            up  = p1_stb & ~p0_stb;
            ser = !p1_bm && p1_sm;
            par = !p1_bm && !p1_sm;
            np  = mdl_pri;
            if (ser && up[0]) begin
                if (p1_stb[2])       mdl_enh = {mdl_enh[6:0], p1_sd};
                else if (!p1_stb[1]) np = {mdl_pri[18:0], p1_sd};
            end
            if ((ser && up[1]) || ((ser || par) && up[6])) mdl_sec = mdl_pri;
            if (par) begin
                if (up[3]) begin np[19] = p1_d[7]; np[16:10] = p1_d[6:0]; end
                if (up[4]) begin np[18:17] = p1_d[1:0]; np[9:8] = p1_d[3:2]; end
                if (up[5]) np[7:0] = p1_d;
                if (up[2]) mdl_enh = p1_d;
            end
            mdl_pri = np;
            p0_stb = p1_stb;
            p1_stb = {hop_wr, a_wr, m2_wr, m1_wr, e_wr, s_wr, sclk};
            p1_d = dbus; p1_sd = sdata; p1_bm = bus_mode; p1_sm = ser_mode;
            p1_sel = use_primary; p1_en = enh_n; p1_da = dir_a; p1_dr = dir_r;
        end
    end

    always @(negedge clk) begin : cmp
        logic [19:0] w;
        if (rst_n && !done) begin
            if (p1_bm) w = {p1_d[7], 2'b00, p1_d[6:0], 2'b00, p1_dr, p1_da};
            else       w = p1_sel ? mdl_pri : mdl_sec;
            check(p1_bm ? "R11 model outputs" : "R9 model outputs",
                  {12'd0, cfg_pre_en, cfg_m, cfg_r, cfg_a}, {12'd0, w});
            check("R10 model enh", {24'd0, enh_bits}, {24'd0, (p1_en ? 8'h00 : mdl_enh)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_stb(input int idx, input logic v);
        case (idx)
            0: sclk = v;  1: s_wr = v;  2: e_wr = v;  3: m1_wr = v;
            4: m2_wr = v; 5: a_wr = v;  default: hop_wr = v;
        endcase
    endtask

    task automatic pulse(input int idx, input logic [7:0] val);
        dbus = val;
        set_stb(idx, 1'b1);
        cyc(2);
        set_stb(idx, 1'b0);
        cyc(2);
    endtask

    task automatic ser_bit(input logic b);
        sdata = b; sclk = 1'b1;
        cyc(1);
        sclk = 1'b0;
        cyc(1);
    endtask

    localparam logic [19:0] SER_WORD = {1'b1, 9'h1A3, 6'h2D, 4'h6};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(2);
        // R12: reset state
        check("R12 reset m", {23'd0, cfg_m}, 32'd0);
        check("R12 reset enh", {24'd0, enh_bits}, 32'd0);
        rst_n = 1'b1;
        use_primary = 1'b1; enh_n = 1'b1;
        cyc(3);
        check("R12 after release pre_en", {31'd0, cfg_pre_en}, 32'd0);

        // parallel mode, R13 latency on m1_wr
        dbus = 8'hA5; m1_wr = 1'b1;
        cyc(1);
        check("R13 write not yet visible", {23'd0, cfg_m}, 32'h000);
        cyc(1);
        check("R5 m1 M", {23'd0, cfg_m}, 32'h025);
        check("R5 m1 pre_en", {31'd0, cfg_pre_en}, 32'd1);
        m1_wr = 1'b0;
        cyc(2);
        pulse(4, 8'h0E);
        check("R6 m2 M", {23'd0, cfg_m}, 32'h125);
        check("R6 m2 R", {26'd0, cfg_r}, 32'h30);
        pulse(5, 8'h9C);
        check("R7 a_wr R", {26'd0, cfg_r}, 32'h39);
        check("R7 a_wr A", {28'd0, cfg_a}, 32'hC);
        enh_n = 1'b0;
        pulse(2, 8'h3C);
        check("R8 parallel enh", {24'd0, enh_bits}, 32'h3C);
        enh_n = 1'b1;
        cyc(1);
        check("R10 enh gated", {24'd0, enh_bits}, 32'h00);
        enh_n = 1'b0;
        use_primary = 1'b0;
        cyc(1);
        check("R9 secondary selected", {23'd0, cfg_m}, 32'h000);
        check("R13 select one cycle", {31'd0, cfg_pre_en}, 32'd0);
        pulse(6, 8'h00);
        check("R4 hop copy M", {23'd0, cfg_m}, 32'h125);
        check("R4 hop copy A", {28'd0, cfg_a}, 32'hC);

        // serial mode
        ser_mode = 1'b1; use_primary = 1'b1;
        cyc(3);
        pulse(3, 8'h00);
        check("R1 m1 ignored in serial", {23'd0, cfg_m}, 32'h125);
        for (int i = 19; i >= 0; i--) ser_bit(SER_WORD[i]);
        cyc(2);
        check("R2 serial word", {12'd0, cfg_pre_en, cfg_m, cfg_r, cfg_a}, {12'd0, SER_WORD});
        e_wr = 1'b1;
        cyc(1);
        for (int i = 7; i >= 0; i--) ser_bit(8'h96 >> i);
        cyc(2);
        check("R3 serial enh", {24'd0, enh_bits}, 32'h96);
        check("R3 primary untouched", {23'd0, cfg_m}, 32'h1A3);
        e_wr = 1'b0;
        use_primary = 1'b0;
        cyc(2);
        check("R9 old secondary", {23'd0, cfg_m}, 32'h125);
        pulse(1, 8'h00);
        check("R4 s_wr copy", {23'd0, cfg_m}, 32'h1A3);

        // direct mode
        bus_mode = 1'b1; dbus = 8'hC7; dir_a = 4'h5; dir_r = 4'hA;
        cyc(1);
        check("R13 direct one cycle", {23'd0, cfg_m}, 32'h047);
        check("R11 direct pre_en", {31'd0, cfg_pre_en}, 32'd1);
        check("R11 direct A", {28'd0, cfg_a}, 32'h5);
        check("R11 direct R", {26'd0, cfg_r}, 32'h0A);
        check("R1 direct mode", {26'd0, cfg_r}, 32'h0A);
        pulse(3, 8'hC7);
        pulse(6, 8'hC7);
        pulse(2, 8'hC7);
        ser_bit(1'b1);
        ser_bit(1'b0);
        cyc(2);
        bus_mode = 1'b0;
        cyc(2);
        check("R11 secondary kept", {23'd0, cfg_m}, 32'h1A3);
        check("R11 enh kept", {24'd0, enh_bits}, 32'h96);
        use_primary = 1'b1;
        cyc(2);
        check("R11 primary kept", {12'd0, cfg_pre_en, cfg_m, cfg_r, cfg_a}, {12'd0, SER_WORD});
        cyc(4);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule